// File: doc/BRIEF.md
# Prescaled 8-bit PWM generator

This block makes one pulse-width-modulated output from a single 32-bit control word. The word is written and read back on a simple bus and holds three fields: a run bit, a step divider, and a duty code. A period is always 256 steps long. Each step lasts a programmable number of clock cycles, so the divider sets the period and the duty code sets how many of the 256 steps are high.

The duty code uses an inverted encoding. The output is high for 256 minus the code steps, counted from the start of the period. Code 0 is reserved and keeps the line low. Divider and duty values written while the output runs are held back until the current period ends, so every period on the pin is a whole one. Each instance runs on its own clock input.

Top module: `pwm8_gen`

## Requirements
- R1: A bus write (`bus_we` high at a rising edge) stores all 32 bits of `bus_wdata`, and `bus_rdata` returns the stored word from the next cycle on.
- R2: Bits 30:16 of the control word read back as written but do not change the output waveform.
- R3: Bit 31 is the run bit. While it is 0 the output is low, and it falls low by the second rising edge after the write that clears the bit. After a write that sets it, the output starts a new period at step 0: the first step is driven from the second rising edge after that write.
- R4: Bits 15:8 hold the divider D. For D from 1 to 255, each step lasts D clocks and the period lasts 256*D clocks.
- R5: A divider field of 0 gives steps of 256 clocks, so the period is 65536 clocks.
- R6: Bits 7:0 hold the duty code C. For C from 1 to 255, the output is high for the first (256-C) steps of each period and low for the rest.
- R7: A duty code of 0 keeps the output low for the whole period while running.
- R8: Divider and duty values written while running take effect only at the next period boundary. The period in progress completes with the old values.
- R9: A synchronous active-high reset clears the control word and forces the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the step time base |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the control word |
| bus_wdata | input | 32 | Control word to store |
| bus_rdata | output | 32 | Stored control word |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The bench builds the block with its default parameters: 8-bit fields in a 32-bit word and 256 steps per period. The field encodings are fixed at these widths. With these values even the largest divider, a field of 0 (256 clocks per step), fits in one 65536-clock window. The bench can therefore measure one full period at every divider extreme, check where the first low step falls, and confirm that the next period begins high again.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_e;

endpackage

// File: rtl/pwm8_ctrl_reg.sv
module pwm8_ctrl_reg #(
  parameter int unsigned STEP_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load_sh,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              en,
  output logic [STEP_W-1:0] reload_sh,
  output logic [STEP_W-1:0] duty_sh
);
  localparam int unsigned EN_POS  = DATA_W - 1;
  localparam int unsigned RLD_LSB = STEP_W;
  localparam int unsigned DTY_LSB = 0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (we) begin
      ctrl_q <= wdata;
    end
  end

  assign en = ctrl_q[EN_POS];

  // Working copy of divider and duty; refreshed only when idle or at a period edge
  always_ff @(posedge clk) begin
    if (rst) begin
      reload_sh <= '0;
      duty_sh   <= '0;
    end else if (load_sh) begin
      reload_sh <= ctrl_q[RLD_LSB +: STEP_W];
      duty_sh   <= ctrl_q[DTY_LSB +: STEP_W];
    end
  end

endmodule

// File: rtl/pwm8_prescaler.sv
module pwm8_prescaler #(
  parameter int unsigned STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [STEP_W-1:0] div_m1,
  output logic              tick,
  output logic [STEP_W-1:0] pre_q
);
  // div_m1 wraps to all ones for a divider field of zero: full 2**STEP_W count
  assign tick = active && (pre_q == div_m1);

  always_ff @(posedge clk) begin
    if (rst || !active || tick) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwm8_phase.sv
module pwm8_phase #(
  parameter int unsigned STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              tick,
  output logic [STEP_W-1:0] phase_q,
  output logic              boundary
);
  localparam logic [STEP_W-1:0] LAST = '1;

  assign boundary = tick && (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      phase_q <= '0;
    end else if (tick) begin
      phase_q <= phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwm8_compare.sv
module pwm8_compare #(
  parameter int unsigned STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [STEP_W-1:0] phase,
  input  logic [STEP_W-1:0] duty,
  output logic              pwm_out
);
  localparam logic [STEP_W:0] STEPS = {1'b1, {STEP_W{1'b0}}};

  logic [STEP_W:0] hi_len;
  logic            hi_zone;

  always_comb begin
    hi_len  = STEPS - {1'b0, duty};
    hi_zone = (duty != '0) && ({1'b0, phase} < hi_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out <= 1'b0;
    end else begin
      pwm_out <= active && hi_zone;
    end
  end

endmodule

// File: rtl/pwm8_gen.sv
module pwm8_gen
  import pwm8_pkg::*;
#(
  parameter int unsigned STEP_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  logic              en;
  logic              active;
  logic              tick;
  logic              boundary;
  logic              load_sh;
  logic [STEP_W-1:0] reload_sh;
  logic [STEP_W-1:0] duty_sh;
  logic [STEP_W-1:0] div_m1;
  logic [STEP_W-1:0] pre_q;
  logic [STEP_W-1:0] phase_q;
  run_e              run_q;

  // One idle cycle after the run bit rises lets the working copy pick up fresh fields
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= ST_IDLE;
    end else begin
      run_q <= en ? ST_RUN : ST_IDLE;
    end
  end

  assign active  = en && (run_q == ST_RUN);
  assign load_sh = !active || boundary;
  assign div_m1  = reload_sh - 1'b1;

  pwm8_ctrl_reg #(.STEP_W(STEP_W), .DATA_W(DATA_W)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .we        (bus_we),
    .wdata     (bus_wdata),
    .load_sh   (load_sh),
    .ctrl_q    (bus_rdata),
    .en        (en),
    .reload_sh (reload_sh),
    .duty_sh   (duty_sh)
  );

  pwm8_prescaler #(.STEP_W(STEP_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .div_m1 (div_m1),
    .tick   (tick),
    .pre_q  (pre_q)
  );

  pwm8_phase #(.STEP_W(STEP_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .tick     (tick),
    .phase_q  (phase_q),
    .boundary (boundary)
  );

  pwm8_compare #(.STEP_W(STEP_W)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .active  (active),
    .phase   (phase_q),
    .duty    (duty_sh),
    .pwm_out (pwm_out)
  );

endmodule

// File: rtl/pwm8_chk.sv
module pwm8_chk #(
  parameter int unsigned STEP_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              pwm_out,
  input logic              active,
  input logic              tick,
  input logic              boundary,
  input logic [STEP_W-1:0] pre_q,
  input logic [STEP_W-1:0] div_m1,
  input logic [STEP_W-1:0] phase_q,
  input logic [STEP_W-1:0] duty_sh,
  input logic [STEP_W-1:0] reload_sh
);

  p_readback_r1: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> (bus_rdata == $past(bus_wdata)));

  p_off_low_r3: assert property (@(posedge clk) disable iff (rst)
    !bus_rdata[DATA_W-1] |=> !pwm_out);

  p_pre_bound_r4: assert property (@(posedge clk) disable iff (rst)
    active |-> (pre_q <= div_m1));

  p_step_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (active && !tick) |=> $stable(phase_q));

  p_zero_low_r7: assert property (@(posedge clk) disable iff (rst)
    (duty_sh == '0) |=> !pwm_out);

  p_duty_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (active && !boundary) |=> ($stable(duty_sh) && $stable(reload_sh)));

endmodule

bind pwm8_gen pwm8_chk #(.STEP_W(STEP_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pwm_out   (pwm_out),
  .active    (active),
  .tick      (tick),
  .boundary  (boundary),
  .pre_q     (pre_q),
  .div_m1    (div_m1),
  .phase_q   (phase_q),
  .duty_sh   (duty_sh),
  .reload_sh (reload_sh)
);

// File: tb/sim_pwm8_gen.sv
`timescale 1ns/1ps
module sim_pwm8_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  pwm8_gen u0 (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  // control words: bit31 run, 15:8 divider, 7:0 duty; some carry junk in 30:16 (R2)
  localparam logic [31:0] VEC [7] = '{
    32'h8000_0180, 32'h8000_0201, 32'h8000_03FF, 32'h8000_0100,
    32'hFFFF_0440, 32'h8000_0040, 32'hAAAA_00C0
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    bus_we = 1'b1;
    bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // Measures one period after a start write: high count, first low index, next-period sample
  task automatic measure(input int len, output int highs, output int first_low, output bit nxt);
    highs = 0;
    first_low = len;
    @(negedge clk);
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      if (pwm_out) highs++;
      else if (first_low == len) first_low = j;
    end
    @(negedge clk);
    nxt = pwm_out;
  endtask

  initial begin
    int hi, fl, dv, cd, exp_hi;
    bit nx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(bus_rdata == 32'h0, "R9 reset word", int'(bus_rdata), 0);
    chk(pwm_out == 1'b0, "R9 reset output", int'(pwm_out), 0);

    // R1/R2/R3: junk in unused bits with run bit clear
    wr(32'h0055_A5C3);
    chk(bus_rdata == 32'h0055_A5C3, "R1 readback", int'(bus_rdata), 32'h0055_A5C3);
    hi = 0;
    for (int j = 0; j < 300; j++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    chk(hi == 0, "R3 idle output low", hi, 0);

    // Table walk: R4 R5 R6 R7 R2
    foreach (VEC[k]) begin
      dv = (VEC[k][15:8] == 0) ? 256 : int'(VEC[k][15:8]);
      cd = int'(VEC[k][7:0]);
      exp_hi = (cd == 0) ? 0 : (256 - cd) * dv;
      wr(32'h0);
      wr(VEC[k]);
      measure(256 * dv, hi, fl, nx);
      chk(hi == exp_hi, "R6/R7 high clocks per period", hi, exp_hi);
      chk(fl == exp_hi, "R3/R6 first low clock", fl, exp_hi);
      if (cd != 0) chk(nx == 1'b1, "R4/R5 next period starts high", int'(nx), 1);
      chk(bus_rdata == VEC[k], "R1 R2 word kept", int'(bus_rdata), int'(VEC[k]));
    end

    // R8: duty change mid-period waits for boundary
    wr(32'h0);
    wr(32'h8000_0180);
    @(negedge clk);
    hi = 0;
    fl = 0;
    for (int j = 0; j < 512; j++) begin
      @(negedge clk);
      if (pwm_out) begin
        if (j < 256) hi++;
        else fl++;
      end
      if (j == 10) begin
        bus_we = 1'b1;
        bus_wdata = 32'h8000_01C0;
      end else if (j == 11) begin
        bus_we = 1'b0;
      end
    end
    chk(hi == 128, "R8 current period keeps old duty", hi, 128);
    chk(fl == 64, "R8 next period uses new duty", fl, 64);

    // R3: clearing run bit mid-period forces low
    wr(32'h8000_0101);
    repeat (5) @(negedge clk);
    wr(32'h0000_0101);
    @(negedge clk);
    hi = 0;
    for (int j = 0; j < 300; j++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    chk(hi == 0, "R3 low after disable", hi, 0);

    // R9: reset while running
    wr(32'h8000_0101);
    repeat (5) @(negedge clk);
    chk(pwm_out == 1'b1, "R6 running high before reset", int'(pwm_out), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(bus_rdata == 32'h0, "R9 word cleared", int'(bus_rdata), 0);
    chk(pwm_out == 1'b0, "R9 output cleared", int'(pwm_out), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(8ns * 190000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule